// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This controller decides when the processor core clock may stop and when it must start again. The pipeline sends a one-cycle pulse when a WAIT instruction completes its writeback stage. If the system bus is idle in that same cycle, the controller drops the core clock enable and raises a standby flag. The frozen pipeline then stays parked until a wake source appears. If the bus is busy, the controller instead tells the pipeline to retire the WAIT as a no-op, and the clock keeps running.

While the core is stopped, the controller itself runs on the free-running clock. It keeps watching these inputs:

- the interrupt request lines;
- the internal timer interrupt;
- the non-maskable interrupt;
- the external request pin;
- the warm and cold reset inputs.

Any interrupt wakes the core. The wake condition passes through a register before the enable returns, so the enable only changes on a clock edge and cannot glitch. Either reset input returns the block to the running state. On every entry into standby, the controller also sends a one-cycle pulse that tells the core to enable interrupts.

Top module: `stby_clkgate_ctrl`

## Requirements
- R1: After either reset input is held high for a clock edge, `core_clk_en` is 1 and `standby`, `wait_nop` and `irq_unmask` are 0.
- R2: When `wait_wb` is 1 and `bus_idle` is 1 while running, `core_clk_en` is 0 and `standby` is 1 from the following cycle.
- R3: When `wait_wb` is 1 and `bus_idle` is 0 while running, `wait_nop` is 1 for exactly the following cycle and `core_clk_en` stays 1.
- R4: `irq_unmask` is 1 for exactly one cycle, the first cycle of each standby period, and at no other time.
- R5: In standby, a 1 on any `irq_lines` bit, on `timer_irq` or on `nmi` at a clock edge sets `core_clk_en` to 1 and `standby` to 0 from the second edge after it (one wake register, then the state change).
- R6: In standby with no interrupt, the block stays in standby. With the default `WAKE_ON_EXTREQ` of 0, `ext_req` has no effect, and `wait_wb` is ignored.
- R7: `rst_warm` or `rst_cold` at a clock edge during standby returns the block to running (`core_clk_en` = 1) from the next cycle.
- R8: `standby` is the inverse of `core_clk_en` in every cycle.
- R9: If an interrupt is already registered when the WAIT completes with the bus idle, standby is entered and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock (not gated) |
| rst_warm | input | 1 | Warm reset, synchronous, active high |
| rst_cold | input | 1 | Cold reset, synchronous, active high |
| wait_wb | input | 1 | One-cycle pulse: WAIT finished writeback |
| bus_idle | input | 1 | System bus has no transaction in progress |
| irq_lines | input | NUM_IRQ | Interrupt request lines, active high |
| timer_irq | input | 1 | Internal timer interrupt, active high |
| nmi | input | 1 | Non-maskable interrupt, active high |
| ext_req | input | 1 | External request, wakes only when WAKE_ON_EXTREQ is 1 |
| core_clk_en | output | 1 | Registered enable for the core clock gate |
| standby | output | 1 | High while the core clock is stopped |
| wait_nop | output | 1 | One-cycle pulse: retire WAIT as a no-op |
| irq_unmask | output | 1 | One-cycle pulse: enable interrupts on standby entry |

## Verification
The embedded properties check several rules on every clock edge:

- the inverse relation between the standby flag and the enable;
- the entry decision and the no-op decision taken at a WAIT pulse;
- the single-cycle unmask pulse on entry;
- holding standby without a wake, and leaving it once the registered wake is seen;
- the reset override.

Some behaviour only the bench scenarios can show. These are the end-to-end latency from an interrupt pin to the enable, through the wake register, and the fact that each wake source (interrupt line, timer and non-maskable interrupt) reaches that register. The same applies to the external request being ignored, and to the one-cycle standby period when an interrupt is already pending at the WAIT.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STBY = 1'b1
  } stby_state_e;

endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
  parameter int NUM_IRQ        = 6,
  parameter int WAKE_STAGES    = 1,
  parameter bit WAKE_ON_EXTREQ = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               timer_irq,
  input  logic               nmi,
  input  logic               ext_req,
  output logic               wake_o
);

  logic                   any_src;
  logic [WAKE_STAGES-1:0] stage_q;

  // Pick the wake source set once at elaboration.
  generate
    if (WAKE_ON_EXTREQ) begin : g_ext_wake
      assign any_src = (|irq_lines) | timer_irq | nmi | ext_req;
    end else begin : g_no_ext_wake
      logic unused_ext;
      assign unused_ext = ext_req;
      assign any_src    = (|irq_lines) | timer_irq | nmi;
    end
  endgenerate

  // Wake path is registered on the free-running clock only.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q <= (stage_q << 1) | WAKE_STAGES'(any_src);
    end
  end

  assign wake_o = stage_q[WAKE_STAGES-1];

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wait_wb,
  input  logic bus_idle,
  input  logic wake,
  output logic clk_en_o,
  output logic standby_o,
  output logic wait_nop_o,
  output logic irq_unmask_o
);

  stby_state_e state_q;
  logic        clk_en_q;
  logic        standby_q;
  logic        nop_q;
  logic        unmask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      clk_en_q  <= 1'b1;
      standby_q <= 1'b0;
      nop_q     <= 1'b0;
      unmask_q  <= 1'b0;
    end else begin
      nop_q    <= 1'b0;
      unmask_q <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (wait_wb) begin
            if (bus_idle) begin
              state_q   <= ST_STBY;
              clk_en_q  <= 1'b0;
              standby_q <= 1'b1;
              unmask_q  <= 1'b1;
            end else begin
              nop_q <= 1'b1;
            end
          end
        end
        ST_STBY: begin
          if (wake) begin
            state_q   <= ST_RUN;
            clk_en_q  <= 1'b1;
            standby_q <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign clk_en_o     = clk_en_q;
  assign standby_o    = standby_q;
  assign wait_nop_o   = nop_q;
  assign irq_unmask_o = unmask_q;

  // R8
  en_vs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    standby_q != clk_en_q);

  // R2
  enter_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_q && wait_wb && bus_idle) |=> (standby_q && !clk_en_q));

  // R3
  busy_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_q && wait_wb && !bus_idle) |=> (nop_q && clk_en_q));

  // R4
  unmask_entry_chk: assert property (@(posedge clk) disable iff (rst)
    unmask_q |-> (standby_q && !$past(standby_q)));

  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (standby_q && wake) |=> clk_en_q);

  // R6
  hold_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (standby_q && !wake) |=> standby_q);

  // R7
  reset_run_chk: assert property (@(posedge clk)
    rst |=> (clk_en_q && !standby_q && !nop_q && !unmask_q));

endmodule

// File: rtl/stby_clkgate_ctrl.sv
module stby_clkgate_ctrl #(
  parameter int NUM_IRQ        = 6,
  parameter int WAKE_STAGES    = 1,
  parameter bit WAKE_ON_EXTREQ = 1'b0
) (
  input  logic               clk,
  input  logic               rst_warm,
  input  logic               rst_cold,
  input  logic               wait_wb,
  input  logic               bus_idle,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               timer_irq,
  input  logic               nmi,
  input  logic               ext_req,
  output logic               core_clk_en,
  output logic               standby,
  output logic               wait_nop,
  output logic               irq_unmask
);

  logic blk_rst;
  logic wake;

  // Either reset input forces the running state.
  assign blk_rst = rst_warm | rst_cold;

  stby_wake_detect #(
    .NUM_IRQ       (NUM_IRQ),
    .WAKE_STAGES   (WAKE_STAGES),
    .WAKE_ON_EXTREQ(WAKE_ON_EXTREQ)
  ) u_wake (
    .clk      (clk),
    .rst      (blk_rst),
    .irq_lines(irq_lines),
    .timer_irq(timer_irq),
    .nmi      (nmi),
    .ext_req  (ext_req),
    .wake_o   (wake)
  );

  stby_fsm u_fsm (
    .clk         (clk),
    .rst         (blk_rst),
    .wait_wb     (wait_wb),
    .bus_idle    (bus_idle),
    .wake        (wake),
    .clk_en_o    (core_clk_en),
    .standby_o   (standby),
    .wait_nop_o  (wait_nop),
    .irq_unmask_o(irq_unmask)
  );

endmodule

// File: tb/stby_clkgate_ctrl_test.sv
`timescale 1ns/1ps
module stby_clkgate_ctrl_test;

  localparam int NIRQ = 6;
  localparam int NROW = 27;
  localparam int RW   = 21;

  logic            clk = 1'b0;
  logic            rst_warm = 1'b0;
  logic            rst_cold = 1'b1;
  logic            wait_wb = 1'b0;
  logic            bus_idle = 1'b0;
  logic [NIRQ-1:0] irq_lines = '0;
  logic            timer_irq = 1'b0;
  logic            nmi = 1'b0;
  logic            ext_req = 1'b0;
  logic            core_clk_en;
  logic            standby;
  logic            wait_nop;
  logic            irq_unmask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stby_clkgate_ctrl #(.NUM_IRQ(NIRQ)) uut (
    .clk(clk), .rst_warm(rst_warm), .rst_cold(rst_cold),
    .wait_wb(wait_wb), .bus_idle(bus_idle), .irq_lines(irq_lines),
    .timer_irq(timer_irq), .nmi(nmi), .ext_req(ext_req),
    .core_clk_en(core_clk_en), .standby(standby),
    .wait_nop(wait_nop), .irq_unmask(irq_unmask)
  );

  // [20:17] tag, [16] wait, [15] idle, [14:9] irq, [8] timer, [7] nmi,
  // [6] ext, [5] warm, [4] cold, [3] en, [2] stby, [1] nop, [0] unmask
  function automatic logic [RW-1:0] row(input int tg, input bit wt, input bit idl,
      input logic [5:0] irq, input bit tmr, input bit nm, input bit ex,
      input bit rw, input bit rc, input bit en, input bit sb, input bit np,
      input bit um);
    return {4'(tg), wt, idl, irq, tmr, nm, ex, rw, rc, en, sb, np, um};
  endfunction

  function automatic string tname(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  localparam logic [RW-1:0] VEC [NROW] = '{
    row(1,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(3,1,0,6'h00,0,0,0,0,0, 1,0,1,0),
    row(3,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(4,0,0,6'h00,0,0,0,0,0, 0,1,0,0),
    row(6,0,0,6'h00,0,0,1,0,0, 0,1,0,0),
    row(6,1,1,6'h00,0,0,1,0,0, 0,1,0,0),
    row(6,0,0,6'h08,0,0,0,0,0, 0,1,0,0),
    row(5,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(5,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(6,0,0,6'h00,1,0,0,0,0, 0,1,0,0),
    row(5,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(6,0,0,6'h00,0,1,0,0,0, 0,1,0,0),
    row(5,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(7,0,0,6'h00,0,0,0,0,1, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(7,0,0,6'h00,0,0,0,1,0, 1,0,0,0),
    row(9,0,0,6'h01,0,0,0,0,0, 1,0,0,0),
    row(9,1,1,6'h01,0,0,0,0,0, 0,1,0,1),
    row(9,0,0,6'h01,0,0,0,0,0, 1,0,0,0),
    row(9,0,0,6'h00,0,0,0,0,0, 1,0,0,0),
    row(2,1,1,6'h00,0,0,0,0,0, 0,1,0,1),
    row(6,0,0,6'h20,0,0,0,0,0, 0,1,0,0),
    row(5,0,0,6'h00,0,0,0,0,0, 1,0,0,0)
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {en,stby,nop,unmask} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic check_r8();
    checks++;
    if (standby !== ~core_clk_en) begin
      errors++;
      $display("FAIL R8: standby %b core_clk_en %b, expected inverse",
               standby, core_clk_en);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    // R1: cold reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", {core_clk_en, standby, wait_nop, irq_unmask}, 4'b1000);
    rst_cold = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      {wait_wb, bus_idle, irq_lines, timer_irq, nmi, ext_req, rst_warm, rst_cold}
        = VEC[i][16:4];
      @(posedge clk);
      @(negedge clk);
      check(tname(int'(VEC[i][20:17])),
            {core_clk_en, standby, wait_nop, irq_unmask}, VEC[i][3:0]);
      check_r8();
    end
    {wait_wb, bus_idle, irq_lines, timer_irq, nmi, ext_req, rst_warm, rst_cold} = '0;

    // R6: long external request in standby never wakes
    wait_wb = 1'b1; bus_idle = 1'b1;
    @(posedge clk); @(negedge clk);
    wait_wb = 1'b0; bus_idle = 1'b0; ext_req = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R6", {core_clk_en, standby, wait_nop, irq_unmask}, 4'b0100);
    ext_req = 1'b0;

    // R7: warm reset held with a WAIT pulse keeps running
    rst_warm = 1'b1; wait_wb = 1'b1; bus_idle = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7", {core_clk_en, standby, wait_nop, irq_unmask}, 4'b1000);
    rst_warm = 1'b0; wait_wb = 1'b0; bus_idle = 1'b0;

    // R5: single-cycle nmi pulse: one edge registers it, next edge exits
    wait_wb = 1'b1; bus_idle = 1'b1;
    @(posedge clk); @(negedge clk);
    wait_wb = 1'b0; bus_idle = 1'b0; nmi = 1'b1;
    @(posedge clk); @(negedge clk);
    nmi = 1'b0;
    check("R5", {core_clk_en, standby, wait_nop, irq_unmask}, 4'b0100);
    @(posedge clk); @(negedge clk);
    check("R5", {core_clk_en, standby, wait_nop, irq_unmask}, 4'b1000);
    check_r8();

    done = 1'b1;
    finish_run();
  end

endmodule